// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupts

This block is a word-addressed general-purpose I/O port of up to 32 pins. Each pin can be turned into an output, driven from a stored output level, or left as an input whose level is brought into the clock domain through a two-stage synchroniser. Software reaches every control and status word over a simple single-cycle register bus (word address, write strobe, write data, combinational read data).

Every pin also has its own event detector. Three configuration words pick the trigger: one chooses level or edge sensing, one chooses the active polarity (high/rising or low/falling), and one turns an edge-sensing pin into an any-transition pin. Detected events latch into a raw pending word. Pending bits are acknowledged by writing ones to a clear word. An enable word masks the pending bits into a status word, and the OR of the status bits drives a single interrupt line towards the system interrupt controller.

A read-only version word reports the build revision. The any-transition configuration word exists only in builds whose revision is 3 or higher; otherwise that address reads zero and ignores writes.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every pin is an input (direction word all ones, `pin_oe` all 0), the output-level word is 0, the enable word is 0, the edge-select and polarity words are all ones (rising-edge sensing), the any-transition word is 0, the pending word is 0 and `irq` is 0.
- R2: A direction bit of 0 makes that pin an output: `pin_oe` is 1 and `pin_out` carries the output-level word bit; a direction bit of 1 makes `pin_oe` 0. Both take effect in the cycle after the write.
- R3: Reading the value word (word address 0) returns, per pin, the synchronised input level for input pins (visible two clock edges after `pin_in` changes) and the output-level word bit for output pins.
- R4: With edge-select bit 0 the pin is level sensed: polarity 1 flags while the synchronised input is 1, polarity 0 while it is 0, and the pending bit is set again every cycle the level stays active, so a clear does not remove it.
- R5: With edge-select bit 1 and any-transition bit 0 the pin is edge sensed: polarity 1 flags a 0-to-1 change, polarity 0 a 1-to-0 change. The pending bit becomes readable three clock edges after `pin_in` changes and then holds until cleared.
- R6: With edge-select bit 1 and any-transition bit 1 the pin flags both rising and falling changes.
- R7: Writing the clear word (word address 5) drops each pending bit whose data bit is 1; bits written 0 are untouched, and an event arriving in the same cycle as its clear leaves the bit set.
- R8: Pending bits latch whether or not the pin is enabled; the status word (word address 3) reads pending AND enable, and `irq` is 1 exactly when some status bit is 1.
- R9: Word addresses are: value 0, direction 1, enable 2, status 3, pending 4, clear 5, edge-select 6, polarity 7, version 8, any-transition 9. The version word reads the build revision (3 by default); status, pending and version ignore writes; the clear word and unused addresses read 0; the any-transition word is writable and reads back when the revision is 3 or higher and reads 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Word address of the register access |
| bus_we | input | 1 | Write strobe, the write commits at the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | NPINS | Raw input levels from the pads |
| pin_out | output | NPINS | Output levels towards the pads |
| pin_oe | output | NPINS | Output enable per pin, 1 drives the pad |
| irq | output | 1 | Combined interrupt, OR of enabled pending bits |

## Verification
The bench aims at the timing edges of the event path: the exact cycle an edge becomes pending (a design with one synchroniser stage too few or too many would show the bit a cycle early or late), the case where a clear and a fresh event share a cycle (a design giving the clear priority would lose the event), and level-sensed pins that must survive a clear while still active (a design that treated them as edges would drop them). It checks that clear ignores zero bits, that masked pins still latch pending while `irq` stays low, and that read-only words refuse writes. A long randomised phase with fixed seed mixes all trigger modes across all pins and compares pending, status and `irq` with values a bench model derives from the trigger rules, catching swapped polarity or a missing any-transition path.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int BUS_AW   = 4;
    localparam int BUS_DW   = 32;
    localparam int MAX_PINS = 32;

    // Word addresses of the register map
    typedef enum logic [BUS_AW-1:0] {
        RG_VALUE = 4'd0,
        RG_DIR   = 4'd1,
        RG_IEN   = 4'd2,
        RG_STAT  = 4'd3,
        RG_PEND  = 4'd4,
        RG_CLR   = 4'd5,
        RG_EDGE  = 4'd6,
        RG_POL   = 4'd7,
        RG_VER   = 4'd8,
        RG_BOTH  = 4'd9
    } reg_sel_e;

    // Trigger configuration of one pin
    typedef struct packed {
        logic edge_mode;   // 0 level, 1 edge
        logic rise_high;   // 1 high/rising, 0 low/falling
        logic any_edge;    // with edge_mode: both directions
    } trig_cfg_t;

    // Decide whether a pin raises an event this cycle
    function automatic logic trig_fire(trig_cfg_t c, logic cur, logic last);
        logic f;
        if (!c.edge_mode)
            f = (cur == c.rise_high);
        else if (c.any_edge)
            f = cur ^ last;
        else if (c.rise_high)
            f = cur & ~last;
        else
            f = ~cur & last;
        return f;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_trig_cell.sv
module gpio_trig_cell
    import gpio_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      lvl,
    input  trig_cfg_t cfg,
    output logic      fire
);
    logic last_q;

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= lvl;
    end

    assign fire = trig_fire(cfg, lvl, last_q);
endmodule

// File: rtl/gpio_pend_bank.sv
module gpio_pend_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] fire,
    input  logic [W-1:0] clr,
    input  logic [W-1:0] ien,
    output logic [W-1:0] pend,
    output logic [W-1:0] masked,
    output logic         irq
);
    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (pend & ~clr) | fire;   // new event wins over clear
    end

    assign masked = pend & ien;
    assign irq    = |masked;
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_irq_pkg::*;
#(
    parameter int W          = 32,
    parameter int HW_VERSION = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    input  logic [W-1:0]      lvl,
    input  logic [W-1:0]      pend,
    input  logic [W-1:0]      masked,
    output logic [W-1:0]      out_val,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      ien_q,
    output logic [W-1:0]      edge_q,
    output logic [W-1:0]      pol_q,
    output logic [W-1:0]      both_q,
    output logic [W-1:0]      clr
);
    localparam bit HAS_BOTH = (HW_VERSION >= 3);

    logic [W-1:0] wd;
    logic         wr_val, wr_dir, wr_ien, wr_edge, wr_pol, wr_both, wr_clr;

    assign wd      = bus_wdata[W-1:0];
    assign wr_val  = bus_we && (bus_addr == RG_VALUE);
    assign wr_dir  = bus_we && (bus_addr == RG_DIR);
    assign wr_ien  = bus_we && (bus_addr == RG_IEN);
    assign wr_edge = bus_we && (bus_addr == RG_EDGE);
    assign wr_pol  = bus_we && (bus_addr == RG_POL);
    assign wr_both = bus_we && (bus_addr == RG_BOTH);
    assign wr_clr  = bus_we && (bus_addr == RG_CLR);

    assign clr = wr_clr ? wd : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_val <= '0;
            dir_q   <= '1;
            ien_q   <= '0;
            edge_q  <= '1;
            pol_q   <= '1;
        end else begin
            if (wr_val)  out_val <= wd;
            if (wr_dir)  dir_q   <= wd;
            if (wr_ien)  ien_q   <= wd;
            if (wr_edge) edge_q  <= wd;
            if (wr_pol)  pol_q   <= wd;
        end
    end

    generate
        if (HAS_BOTH) begin : g_both
            always_ff @(posedge clk) begin
                if (rst)          both_q <= '0;
                else if (wr_both) both_q <= wd;
            end
        end else begin : g_no_both
            assign both_q = '0;
        end
    endgenerate

    logic [W-1:0] rd_pins;

    always_comb begin
        rd_pins = '0;
        case (bus_addr)
            RG_VALUE: rd_pins = (lvl & dir_q) | (out_val & ~dir_q);
            RG_DIR:   rd_pins = dir_q;
            RG_IEN:   rd_pins = ien_q;
            RG_STAT:  rd_pins = masked;
            RG_PEND:  rd_pins = pend;
            RG_EDGE:  rd_pins = edge_q;
            RG_POL:   rd_pins = pol_q;
            RG_BOTH:  rd_pins = both_q;
            default:  rd_pins = '0;
        endcase
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == RG_VER) bus_rdata = BUS_DW'(HW_VERSION);
        else                    bus_rdata[W-1:0] = rd_pins;
    end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int NPINS      = 32,
    parameter int HW_VERSION = 3,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    logic [NPINS-1:0] lvl_sync, fire_vec, pend_vec, masked_vec, clr_vec;
    logic [NPINS-1:0] out_val, dir_q, ien_q, edge_q, pol_q, both_q;

    gpio_sync #(.W(NPINS), .STAGES(SYNC_DEPTH)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (lvl_sync)
    );

    generate
        for (genvar i = 0; i < NPINS; i++) begin : g_pin
            trig_cfg_t cfg;
            assign cfg = '{edge_mode: edge_q[i], rise_high: pol_q[i], any_edge: both_q[i]};
            gpio_trig_cell u_cell (
                .clk  (clk),
                .rst  (rst),
                .lvl  (lvl_sync[i]),
                .cfg  (cfg),
                .fire (fire_vec[i])
            );
        end
    endgenerate

    gpio_pend_bank #(.W(NPINS)) u_pend (
        .clk    (clk),
        .rst    (rst),
        .fire   (fire_vec),
        .clr    (clr_vec),
        .ien    (ien_q),
        .pend   (pend_vec),
        .masked (masked_vec),
        .irq    (irq)
    );

    gpio_regfile #(.W(NPINS), .HW_VERSION(HW_VERSION)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .lvl       (lvl_sync),
        .pend      (pend_vec),
        .masked    (masked_vec),
        .out_val   (out_val),
        .dir_q     (dir_q),
        .ien_q     (ien_q),
        .edge_q    (edge_q),
        .pol_q     (pol_q),
        .both_q    (both_q),
        .clr       (clr_vec)
    );

    assign pin_out = out_val;
    assign pin_oe  = ~dir_q;
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
    import gpio_irq_pkg::*;
#(
    parameter int NPINS      = 32,
    parameter int HW_VERSION = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [BUS_AW-1:0] bus_addr,
    input logic              bus_we,
    input logic [BUS_DW-1:0] bus_wdata,
    input logic [BUS_DW-1:0] bus_rdata,
    input logic [NPINS-1:0]  pin_oe,
    input logic              irq,
    input logic [NPINS-1:0]  pend,
    input logic [NPINS-1:0]  clr
);
    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    // R1: first cycle out of reset is quiet
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        rst_d |-> (!irq && pin_oe == '0));

    // R2: output enables follow a direction write on the next cycle
    a_r2_oe_follows_dir: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == RG_DIR) |=> (pin_oe == ~$past(bus_wdata[NPINS-1:0])));

    // R7: a pending bit only falls when a clear names it
    a_r7_pend_holds: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(pend) & ~$past(clr)) & ~pend) == '0));

    // R8: disabling every pin silences the interrupt
    a_r8_mask_off: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == RG_IEN && bus_wdata[NPINS-1:0] == '0) |=> !irq);

    // R8: the interrupt needs a pending bit behind it
    a_r8_irq_has_pend: assert property (@(posedge clk) disable iff (rst)
        irq |-> (pend != '0));

    // R9: version word reads the build revision
    a_r9_version_ro: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == RG_VER) |-> (bus_rdata == BUS_DW'(HW_VERSION)));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPINS(NPINS), .HW_VERSION(HW_VERSION)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .pend      (pend_vec),
    .clr       (clr_vec)
);

// File: tb/gpio_irq_port_bench.sv
module gpio_irq_port_bench;
    localparam logic [3:0] A_VAL  = 4'd0, A_DIR = 4'd1, A_IEN = 4'd2, A_STAT = 4'd3,
                           A_PEND = 4'd4, A_CLR = 4'd5, A_EDGE = 4'd6, A_POL = 4'd7,
                           A_VER  = 4'd8, A_BOTH = 4'd9;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  addr;
    logic        we;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [31:0] pin_in;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    gpio_irq_port u_gpio_irq_port (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    function automatic logic [31:0] lvl_act(logic [31:0] e, logic [31:0] p, logic [31:0] v);
        return ~e & ~(v ^ p);
    endfunction

    function automatic logic [31:0] edge_evt(logic [31:0] e, logic [31:0] p, logic [31:0] b,
                                             logic [31:0] o, logic [31:0] n);
        return e & ((b & (o ^ n)) | (~b & ((p & n & ~o) | (~p & o & ~n))));
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic chk_reg(string tag, logic [3:0] a, logic [31:0] exp);
        addr = a;
        #1;
        chk(tag, rdata, exp);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog got=running exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] e, p, b, ie, cur, nxt, exp;
        rst = 1'b1; we = 1'b0; addr = '0; wdata = '0; pin_in = '0;
        void'($urandom(32'd4711));
        tick(4);
        rst = 1'b0;
        tick(1);

        // R1 reset state
        chk_reg("R1 dir", A_DIR, 32'hFFFF_FFFF);
        chk("R1 pin_oe", pin_oe, 32'h0);
        chk("R1 pin_out", pin_out, 32'h0);
        chk_reg("R1 ien", A_IEN, 32'h0);
        chk_reg("R1 edge", A_EDGE, 32'hFFFF_FFFF);
        chk_reg("R1 pol", A_POL, 32'hFFFF_FFFF);
        chk_reg("R1 both", A_BOTH, 32'h0);
        chk_reg("R1 pend", A_PEND, 32'h0);
        chk("R1 irq", {31'd0, irq}, 32'h0);

        // R2 direction and outputs
        wr(A_VAL, 32'hA5A5_1234);
        wr(A_DIR, 32'hFFFF_0000);
        chk("R2 pin_oe", pin_oe, 32'h0000_FFFF);
        chk("R2 pin_out", pin_out, 32'hA5A5_1234);

        // R3 value read mixes inputs and outputs
        @(negedge clk); pin_in = 32'h5A5A_00FF;
        tick(1);
        chk_reg("R3 one edge only", A_VAL, 32'h0000_1234);
        tick(1);
        chk_reg("R3 value mix", A_VAL, 32'h5A5A_1234);
        wr(A_DIR, 32'hFFFF_FFFF);
        chk("R2 all inputs", pin_oe, 32'h0);
        chk_reg("R3 all inputs", A_VAL, 32'h5A5A_00FF);
        @(negedge clk); pin_in = '0;
        tick(4);
        wr(A_CLR, 32'hFFFF_FFFF);
        chk_reg("R7 clear all", A_PEND, 32'h0);

        // R5 rising edge on pin 3 with latency
        wr(A_IEN, 32'h0000_0008);
        @(negedge clk); pin_in[3] = 1'b1;
        tick(2);
        chk_reg("R5 not yet", A_PEND, 32'h0);
        tick(1);
        chk_reg("R5 rise pend", A_PEND, 32'h0000_0008);
        chk("R8 irq on", {31'd0, irq}, 32'h1);
        @(negedge clk); pin_in[3] = 1'b0;
        tick(4);
        chk_reg("R5 held", A_PEND, 32'h0000_0008);
        wr(A_CLR, 32'h0000_0008);
        chk_reg("R7 cleared", A_PEND, 32'h0);
        chk("R8 irq off", {31'd0, irq}, 32'h0);

        // R5 falling edge on pin 4
        wr(A_POL, 32'hFFFF_FFEF);
        @(negedge clk); pin_in[4] = 1'b1;
        tick(4);
        chk_reg("R5 fall ignores rise", A_PEND, 32'h0);
        @(negedge clk); pin_in[4] = 1'b0;
        tick(4);
        chk_reg("R5 fall pend", A_PEND, 32'h0000_0010);
        wr(A_CLR, 32'h0000_0010);

        // R4 level high on pin 6, level low on pin 7
        wr(A_EDGE, 32'hFFFF_FF3F);
        wr(A_POL, 32'hFFFF_FF7F);
        wr(A_CLR, 32'hFFFF_FFFF);
        chk_reg("R4 low level active", A_PEND, 32'h0000_0080);
        @(negedge clk); pin_in[6] = 1'b1; pin_in[7] = 1'b1;
        tick(4);
        wr(A_CLR, 32'hFFFF_FFFF);
        chk_reg("R4 high level survives clear", A_PEND, 32'h0000_0040);
        @(negedge clk); pin_in[6] = 1'b0;
        tick(4);
        wr(A_CLR, 32'hFFFF_FFFF);
        chk_reg("R4 level gone", A_PEND, 32'h0);
        @(negedge clk); pin_in[7] = 1'b0;
        tick(4);
        wr(A_EDGE, 32'hFFFF_FFFF);
        wr(A_POL, 32'hFFFF_FFFF);
        wr(A_CLR, 32'hFFFF_FFFF);

        // R6 both edges on pin 9
        wr(A_BOTH, 32'h0000_0200);
        chk_reg("R9 both readback", A_BOTH, 32'h0000_0200);
        @(negedge clk); pin_in[9] = 1'b1;
        tick(4);
        chk_reg("R6 rise", A_PEND, 32'h0000_0200);
        wr(A_CLR, 32'h0000_0200);
        @(negedge clk); pin_in[9] = 1'b0;
        tick(4);
        chk_reg("R6 fall", A_PEND, 32'h0000_0200);

        // R7 zero bits in clear do nothing
        @(negedge clk); pin_in[3] = 1'b1;
        tick(4);
        wr(A_CLR, 32'h0000_0200);
        chk_reg("R7 partial clear", A_PEND, 32'h0000_0008);
        wr(A_CLR, 32'hFFFF_FFFF);

        // R7 clear and event in the same cycle
        @(negedge clk); pin_in[11] = 1'b1;
        tick(1);
        wr(A_CLR, 32'h0000_0800);
        chk_reg("R7 event beats clear", A_PEND, 32'h0000_0800);
        wr(A_CLR, 32'h0000_0800);
        chk_reg("R7 later clear", A_PEND, 32'h0);

        // R8 masked pin still latches
        wr(A_IEN, 32'h0);
        @(negedge clk); pin_in[12] = 1'b1;
        tick(4);
        chk_reg("R8 masked pend", A_PEND, 32'h0000_1000);
        chk_reg("R8 masked stat", A_STAT, 32'h0);
        chk("R8 masked irq", {31'd0, irq}, 32'h0);
        wr(A_IEN, 32'h0000_1000);
        chk_reg("R8 stat on", A_STAT, 32'h0000_1000);
        chk("R8 irq after enable", {31'd0, irq}, 32'h1);

        // R9 read-only and unmapped words
        chk_reg("R9 version", A_VER, 32'd3);
        wr(A_VER, 32'h0000_00FF);
        chk_reg("R9 version ro", A_VER, 32'd3);
        wr(A_PEND, 32'h0);
        chk_reg("R9 pend ro", A_PEND, 32'h0000_1000);
        wr(A_STAT, 32'h0);
        chk_reg("R9 stat ro", A_STAT, 32'h0000_1000);
        chk_reg("R9 clear reads 0", A_CLR, 32'h0);
        chk_reg("R9 unmapped", 4'd12, 32'h0);

        // Random phase over all modes (R4 R5 R6 R8)
        cur = pin_in;
        tick(4);
        for (int it = 0; it < 40; it++) begin
            e  = $urandom; p = $urandom; b = $urandom; ie = $urandom;
            wr(A_EDGE, e); wr(A_POL, p); wr(A_BOTH, b); wr(A_IEN, ie);
            wr(A_CLR, 32'hFFFF_FFFF);
            chk_reg("R4 rand after clear", A_PEND, lvl_act(e, p, cur));
            nxt = $urandom;
            @(negedge clk); pin_in = nxt;
            tick(4);
            exp = lvl_act(e, p, cur) | lvl_act(e, p, nxt) | edge_evt(e, p, b, cur, nxt);
            chk_reg("R5 R6 rand pend", A_PEND, exp);
            chk_reg("R8 rand stat", A_STAT, exp & ie);
            chk("R8 rand irq", {31'd0, irq}, {31'd0, |(exp & ie)});
            cur = nxt;
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule